// File: doc/BRIEF.md
# Register-Enabled Scan Mode Controller

This block switches a small synchronous datapath into serial scan test without a dedicated scan-enable pin. A plain write port (strobe, address, data) feeds a decoder. The decoder sets or clears one internal mode flop, and the output of that flop is the sole select for every scan cell. The mode flop starts cleared after reset, so the design comes up in functional mode.

The functional payload is a pulse counter. Each cycle in which the shared input pin is high, the counter goes up by one. In functional mode the shared output pin carries the parity of the count. In scan mode the same flops form one serial chain, from the shared input pin through count bit 0, then bit 1, and so on up to the top bit. The shared output pin then carries the last stage. The functional clock also serves as the shift clock, and no clock passes through logic.

The mode flop and its decoder stay outside the chain. They keep decoding writes while scan is active, so a write can still take the design back to functional mode.

Top module: `regscan_top`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears the counter to 0 and clears scan mode, so pin_out reads 0 (the parity of 0).
- R2: A write with wr_en high, wr_addr equal to SCAN_ADDR (default 8'h3C) and wr_data equal to 1 sets scan mode from the next cycle on.
- R3: A write to any other address, or a write to SCAN_ADDR with any data other than 0 or 1, leaves the mode unchanged, whether the design is in functional or scan mode.
- R4: A write of 0 to SCAN_ADDR clears scan mode. The decoder acts on this write while scan mode is active, and counting resumes on the following cycle.
- R5: In scan mode every clock edge moves count bit i-1 into bit i, and pin_in into bit 0. The order is fixed: bit 0 is the first stage and bit CNT_W-1 is the last.
- R6: pin_out shows the last chain stage (count_q[CNT_W-1]) while scan mode is set, and the XOR of all count bits otherwise.
- R7: In functional mode the counter adds pin_in on each clock edge and wraps from all ones to 0.
- R8: After scan mode is entered, a bit driven on pin_in before clock edge j appears on pin_out after edge j+CNT_W-1, so the serial stream comes out delayed by the chain length.
- R9: A reset applied while scan mode is active returns the design to functional counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock, also the shift clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| pin_in | input | 1 | Count input in functional mode; scan-in in scan mode |
| pin_out | output | 1 | Count parity in functional mode; scan-out in scan mode |
| count_q | output | CNT_W | Counter value; the chain contents in scan mode |

## Verification
Long runs of counting pulses, including one that wraps all the way around, show functional increments apart from shifting. A mixed 24-bit pattern shifted through the chain catches a swapped or dropped stage and a wrong delay at pin_out. Writes to a foreign address and writes of off values such as 2 and 0xFF to the scan address are each followed by a single pulse. Because a single pulse gives an increment in one mode and a shift in the other, these tests show the mode was left alone. A reset and a write of 0 issued during scan then confirm that both ways out restore counting.

// File: rtl/regscan_pkg.sv
package regscan_pkg;

   // Decoded effect of one write on the scan-mode flop
   typedef enum logic [1:0] {
      MODE_KEEP  = 2'd0,
      MODE_SET   = 2'd1,
      MODE_CLEAR = 2'd2
   } mode_act_e;

   // Data codes recognised at the scan address
   localparam int unsigned CODE_ENTER = 1;
   localparam int unsigned CODE_LEAVE = 0;

endpackage

// File: rtl/regscan_decode.sv
module regscan_decode
   import regscan_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 8,
   parameter logic [ADDR_W-1:0] SCAN_ADDR = 8'h3C
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output mode_act_e         act
);

   localparam logic [DATA_W-1:0] ENTER_V = DATA_W'(CODE_ENTER);
   localparam logic [DATA_W-1:0] LEAVE_V = DATA_W'(CODE_LEAVE);

   if (DATA_W < 1) begin : g_bad_data
      $error("regscan_decode: DATA_W must be at least 1");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("regscan_decode: ADDR_W must be at least 1");
   end

   logic hit;

   always_comb begin
      hit = wr_en && (wr_addr == SCAN_ADDR);
      act = MODE_KEEP;
      if (hit) begin
         if (wr_data == ENTER_V) begin
            act = MODE_SET;
         end else if (wr_data == LEAVE_V) begin
            act = MODE_CLEAR;
         end
      end
   end

endmodule

// File: rtl/regscan_mode_reg.sv
module regscan_mode_reg
   import regscan_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  mode_act_e act,
   output logic      scan_en
);

   logic mode_d;

   always_comb begin
      unique case (act)
         MODE_SET:   mode_d = 1'b1;
         MODE_CLEAR: mode_d = 1'b0;
         default:    mode_d = scan_en;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scan_en <= 1'b0;
      end else begin
         scan_en <= mode_d;
      end
   end

endmodule

// File: rtl/regscan_cell.sv
module regscan_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_scan,
   input  logic d_func,
   input  logic d_scan,
   output logic q
);

   logic d_mux;

   always_comb begin
      d_mux = sel_scan ? d_scan : d_func;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= 1'b0;
      end else begin
         q <= d_mux;
      end
   end

endmodule

// File: rtl/regscan_payload.sv
module regscan_payload #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scan_en,
   input  logic             pin_in,
   output logic [CNT_W-1:0] cnt
);

   if (CNT_W < 2) begin : g_bad_width
      $error("regscan_payload: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] next_cnt;
   logic [CNT_W-1:0] shift_src;

   always_comb begin
      next_cnt = cnt + CNT_W'(pin_in);
   end

   for (genvar i = 0; i < CNT_W; i++) begin : g_stage
      if (i == 0) begin : g_head
         assign shift_src[i] = pin_in;
      end else begin : g_body
         assign shift_src[i] = cnt[i-1];
      end

      regscan_cell u_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .sel_scan (scan_en),
         .d_func   (next_cnt[i]),
         .d_scan   (shift_src[i]),
         .q        (cnt[i])
      );
   end

endmodule

// File: rtl/regscan_pinmux.sv
module regscan_pinmux #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             scan_en,
   input  logic [CNT_W-1:0] cnt,
   output logic             pin_out
);

   localparam int unsigned TAIL = CNT_W - 1;

   logic func_val;
   logic scan_val;

   always_comb begin
      func_val = ^cnt;
      scan_val = cnt[TAIL];
      pin_out  = scan_en ? scan_val : func_val;
   end

endmodule

// File: rtl/regscan_top.sv
module regscan_top
   import regscan_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned CNT_W     = 8,
   parameter logic [ADDR_W-1:0] SCAN_ADDR = 8'h3C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              pin_in,
   output logic              pin_out,
   output logic [CNT_W-1:0]  count_q
);

   if (CNT_W < 2) begin : g_bad_cnt
      $error("regscan_top: chain needs at least two stages");
   end

   mode_act_e act;
   logic      scan_en;

   regscan_decode #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .SCAN_ADDR (SCAN_ADDR)
   ) u_decode (
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .act     (act)
   );

   regscan_mode_reg u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .act     (act),
      .scan_en (scan_en)
   );

   regscan_payload #(
      .CNT_W (CNT_W)
   ) u_payload (
      .clk     (clk),
      .rst_n   (rst_n),
      .scan_en (scan_en),
      .pin_in  (pin_in),
      .cnt     (count_q)
   );

   regscan_pinmux #(
      .CNT_W (CNT_W)
   ) u_pinmux (
      .scan_en (scan_en),
      .cnt     (count_q),
      .pin_out (pin_out)
   );

endmodule

// File: rtl/regscan_checker.sv
module regscan_checker #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned CNT_W     = 8,
   parameter logic [ADDR_W-1:0] SCAN_ADDR = 8'h3C
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              pin_in,
   input logic              pin_out,
   input logic [CNT_W-1:0]  count_q,
   input logic              scan_en
);

   logic hit_set;
   logic hit_clr;

   always_comb begin
      hit_set = wr_en && (wr_addr == SCAN_ADDR) && (wr_data == DATA_W'(1));
      hit_clr = wr_en && (wr_addr == SCAN_ADDR) && (wr_data == DATA_W'(0));
   end

   AST_RESET_CLEARS: assert property (@(posedge clk)
      !rst_n |=> (!scan_en && count_q == '0)); // R1

   AST_ENTER_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && hit_set) |=> scan_en); // R2

   AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && !hit_set && !hit_clr) |=> $stable(scan_en)); // R3

   AST_LEAVE_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && hit_clr) |=> !scan_en); // R4

   AST_CHAIN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && scan_en) |=> (count_q[CNT_W-1:1] == $past(count_q[CNT_W-2:0])
                              && count_q[0] == $past(pin_in))); // R5

   AST_PIN_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
      scan_en |-> (pin_out == count_q[CNT_W-1])); // R6

   AST_PIN_FUNC: assert property (@(posedge clk) disable iff (!rst_n)
      !scan_en |-> (pin_out == ^count_q)); // R6

   AST_FUNC_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && !scan_en) |=> (count_q == $past(count_q) + CNT_W'($past(pin_in)))); // R7

endmodule

bind regscan_top regscan_checker #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .CNT_W     (CNT_W),
   .SCAN_ADDR (SCAN_ADDR)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .pin_in  (pin_in),
   .pin_out (pin_out),
   .count_q (count_q),
   .scan_en (scan_en)
);

// File: tb/sim_regscan_top.sv
`timescale 1ns/1ps
module sim_regscan_top;

   localparam int unsigned AW = 8;
   localparam int unsigned DW = 8;
   localparam int unsigned CW = 8;
   localparam logic [AW-1:0] SA = 8'h3C;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          pin_in = 1'b0;
   logic          pin_out;
   logic [CW-1:0] count_q;

   int n_run  = 0;
   int n_fail = 0;
   logic [CW-1:0] model;

   always #5 clk = ~clk;

   regscan_top #(
      .ADDR_W (AW), .DATA_W (DW), .CNT_W (CW), .SCAN_ADDR (SA)
   ) u0 (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
      .wr_data (wr_data), .pin_in (pin_in), .pin_out (pin_out), .count_q (count_q)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one clock with pin_in held at b; returns at the following falling edge
   task automatic tick(input logic b);
      pin_in = b;
      @(negedge clk);
   endtask

   task automatic reg_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d; pin_in = 1'b0;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      tick(1'b0); tick(1'b0); tick(1'b0);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 count after reset", 32'(count_q), 32'h0);
      chk("R1 pin_out after reset", 32'(pin_out), 32'h0);
   endtask

   task automatic t_count();
      for (int i = 0; i < 5; i++) tick(1'b1);
      for (int i = 0; i < 3; i++) tick(1'b0);
      chk("R7 count of five pulses", 32'(count_q), 32'd5);
      chk("R6 functional parity", 32'(pin_out), 32'(^count_q));
      for (int i = 0; i < 256; i++) tick(1'b1);
      chk("R7 full wrap", 32'(count_q), 32'd5);
      for (int i = 0; i < 250; i++) tick(1'b1);
      chk("R7 all ones", 32'(count_q), 32'd255);
      chk("R6 parity of all ones", 32'(pin_out), 32'd0);
      tick(1'b1);
      chk("R7 wrap to zero", 32'(count_q), 32'd0);
      tick(1'b0);
   endtask

   task automatic t_ignore_func();
      logic [CW-1:0] prev;
      for (int i = 0; i < 4; i++) tick(1'b1);
      prev = count_q;
      reg_write(8'h3D, 8'h01);
      tick(1'b1);
      chk("R3 other address keeps counting", 32'(count_q), 32'(prev + 8'd1));
      prev = count_q;
      reg_write(SA, 8'h02);
      tick(1'b1);
      chk("R3 data 2 at scan address ignored", 32'(count_q), 32'(prev + 8'd1));
      prev = count_q;
      reg_write(SA, 8'hFF);
      tick(1'b1);
      chk("R3 data FF at scan address ignored", 32'(count_q), 32'(prev + 8'd1));
      chk("R6 pin_out still parity", 32'(pin_out), 32'(^count_q));
   endtask

   task automatic t_scan_shift();
      logic [23:0] pat = 24'b1011_0011_1000_1101_0110_0101;
      // count is 7 (binary 00000111): top bit 0, parity 1
      reg_write(SA, 8'h01);
      model = count_q;
      chk("R2 count unchanged by write", 32'(count_q), 32'd7);
      chk("R6 pin_out shows last stage", 32'(pin_out), 32'(model[CW-1]));
      for (int j = 0; j < 24; j++) begin
         tick(pat[j]);
         model = {model[CW-2:0], pat[j]};
         chk("R5 chain contents", 32'(count_q), 32'(model));
         if (j >= CW - 1) begin
            chk("R8 delayed output bit", 32'(pin_out), 32'(pat[j-CW+1]));
         end
      end
      reg_write(SA, 8'h02);
      model = {model[CW-2:0], 1'b0};
      chk("R3 odd data in scan mode: still shifting", 32'(count_q), 32'(model));
      reg_write(8'h11, 8'h00);
      model = {model[CW-2:0], 1'b0};
      chk("R3 foreign clear in scan mode", 32'(count_q), 32'(model));
      chk("R6 pin_out still last stage", 32'(pin_out), 32'(model[CW-1]));
   endtask

   task automatic t_exit();
      reg_write(SA, 8'h00);
      // the write edge still shifts a zero in
      model = {model[CW-2:0], 1'b0};
      chk("R4 last shift at exit write", 32'(count_q), 32'(model));
      chk("R6 parity after exit", 32'(pin_out), 32'(^model));
      tick(1'b1);
      chk("R4 counting resumed", 32'(count_q), 32'(model + 8'd1));
   endtask

   task automatic t_reset_in_scan();
      reg_write(SA, 8'h01);
      do_reset();
      chk("R9 count cleared", 32'(count_q), 32'h0);
      tick(1'b1);
      tick(1'b1);
      chk("R9 functional after reset", 32'(count_q), 32'd2);
      chk("R1 parity after reset", 32'(pin_out), 32'd1);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_count();
      t_ignore_func();
      t_scan_shift();
      t_exit();
      t_reset_in_scan();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #200000;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule